// File: doc/BRIEF.md
# Write-Protect Register and Block-Lock Controller

This block owns the protection state of a 2048-byte serial nonvolatile memory and rules on every write that the bus transaction layer decodes. For each data byte the transaction layer presents an address, the byte, and a flag that tells whether the transaction is a single-byte random write. The block answers at once with an acknowledge verdict. It keeps the accepted operation pending until the transaction layer sends a commit strobe, which marks the bus stop condition. On commit it updates its latches and requests either a volatile cycle (one clock) or a nonvolatile cycle (a counted busy window).

The control register lives at the top address of the array. Two latches gate writes: a general write-enable latch and a register-write latch. Both clear on a modelled power-up event. Two block-protect bits and a hardware-lock enable bit survive power-up. A three-step unlock is needed to change them: enable writes, arm the register latch, then write the new values. That last write disarms the register latch again. Once the lock enable bit is set and the write-protect pin is high, the protect bits and the lock enable itself can no longer be changed.

Top module: `wp_lock_ctrl`

## Requirements
- R1: `reg_rdata_o` shows the write-enable latch in bit 1, the register-write latch in bit 2, block-protect bit 0 in bit 3, block-protect bit 1 in bit 4 and the lock enable in bit 7. Bits 0, 5 and 6 read 0. After `rst_ni` the whole value is 0x00.
- R2: A cycle with `pwr_up_i` high clears bits 1 and 2 and drops any pending operation. Bits 3, 4 and 7 keep their values.
- R3: An array write is any byte whose address is not 0x7FF, or whose single flag is 0. It is acknowledged only when the write-enable latch is 1, the address is outside the protected range and `busy_o` is low.
- R4: The protected range is chosen by {bit4,bit3}. 00 protects nothing. 01 protects addresses with the top two bits 11 (0x600-0x7FF). 10 protects addresses with the top bit 1 (0x400-0x7FF). 11 protects every array address.
- R5: A single-byte write of 0x00 to 0x7FF is acknowledged and clears both latches at commit. A single-byte write whose bits 7:1 are 0000001 sets the write-enable latch at commit, unless R7 applies.
- R6: A single-byte write to 0x7FF with bits 6:5 = 00 and bits 2:1 = 11 is acknowledged only while the write-enable latch is 1. At commit it sets the register-write latch and leaves bits 3, 4 and 7 unchanged.
- R7: While the register-write latch is 1, a single-byte write to 0x7FF with bits 6:5 = 00 and bits 2:0 = 010 is a nonvolatile write. At commit it loads bit 7, bit 4 and bit 3 from the data and clears the register-write latch. Register writes matching none of R5-R7 are not acknowledged.
- R8: When `wp_i` and the lock enable are both 1, the nonvolatile write of R7 is not acknowledged. A nonvolatile write already pending is dropped at commit if the lock is active in that cycle, with no `nv_cycle_o`.
- R9: State changes only in a cycle with `commit_i` high, and applies the most recently acknowledged operation. A request in the commit cycle is not captured. A committed array or nonvolatile register write drives `nv_cycle_o` high in the commit cycle, and `busy_o` is then high for exactly BUSY_CYCLES cycles.
- R10: A committed latch write drives `vol_cycle_o` high in the commit cycle and does not raise `busy_o`.
- R11: While `busy_o` is high, no request is acknowledged.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all state |
| pwr_up_i | input | 1 | Modelled power-up event, clears the volatile latches |
| req_valid_i | input | 1 | A decoded data byte write is presented |
| req_addr_i | input | 11 | Byte address of the write |
| req_data_i | input | 8 | Data byte |
| req_single_i | input | 1 | Transaction is a single-byte random write |
| wp_i | input | 1 | Write-protect pin |
| commit_i | input | 1 | Stop-condition strobe, commits the pending operation |
| ack_o | output | 1 | Acknowledge verdict for the presented byte |
| vol_cycle_o | output | 1 | Volatile latch write committed this cycle |
| nv_cycle_o | output | 1 | Nonvolatile write cycle starts this cycle |
| busy_o | output | 1 | Nonvolatile cycle in progress |
| reg_rdata_o | output | 8 | Control register read value |

## Verification
The hardest state to reach is a nonvolatile register write that was accepted with the pin low and then meets an active hardware lock at commit. Getting there takes the full unlock, setting the lock enable, re-arming the register latch with the pin high, and only then dropping the pin to queue the write before raising it for the stop strobe. The stimulus walks that path step by step, waiting out each busy window. It also exercises the pattern overlap where 0x02 means "enable" or "clear everything nonvolatile" depending on the register latch. A behavioural model predicts every output on every clock.

// File: rtl/wpl_pkg.sv
package wpl_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SET_WEN  = 3'd1,
    OP_CLR_WEN  = 3'd2,
    OP_SET_ARM  = 3'd3,
    OP_NV_REG   = 3'd4,
    OP_ARRAY    = 3'd5
  } wpl_op_e;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] bp;
    logic       arm;
    logic       wen;
  } wpl_state_t;

  localparam int unsigned BIT_WEN  = 1;
  localparam int unsigned BIT_ARM  = 2;
  localparam int unsigned BIT_BP0  = 3;
  localparam int unsigned BIT_BP1  = 4;
  localparam int unsigned BIT_LOCK = 7;
endpackage

// File: rtl/wpl_decode.sv
module wpl_decode
  import wpl_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic              req_single_i,
  input  wpl_state_t        st_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              ack_o,
  output wpl_op_e           op_o
);
  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

  logic hw_lock;
  logic reg_hit;
  logic in_prot;
  logic pat_arm, pat_nv, pat_wen;
  wpl_op_e op_reg, op_arr;

  assign hw_lock = wp_i & st_i.lock_en;
  assign reg_hit = req_single_i && (req_addr_i == REG_ADDR);

  always_comb begin
    unique case (st_i.bp)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = &req_addr_i[ADDR_W-1 -: 2];
      2'b10:   in_prot = req_addr_i[ADDR_W-1];
      default: in_prot = 1'b1;
    endcase
  end

  assign pat_arm = (req_data_i[6:5] == 2'b00) && (req_data_i[2:1] == 2'b11);
  assign pat_nv  = (req_data_i[6:5] == 2'b00) && (req_data_i[2:0] == 3'b010);
  assign pat_wen = (req_data_i[7:1] == 7'b0000001);

  // ordering matters: 0x02 is a nv write while armed, an enable otherwise
  always_comb begin
    op_reg = OP_NONE;
    if (req_data_i == 8'h00)    op_reg = OP_CLR_WEN;
    else if (pat_arm)           op_reg = st_i.wen ? OP_SET_ARM : OP_NONE;
    else if (st_i.arm && pat_nv) op_reg = hw_lock ? OP_NONE : OP_NV_REG;
    else if (pat_wen)           op_reg = OP_SET_WEN;
  end

  assign op_arr = (st_i.wen && !in_prot) ? OP_ARRAY : OP_NONE;

  always_comb begin
    op_o = OP_NONE;
    if (req_valid_i && !busy_i) op_o = reg_hit ? op_reg : op_arr;
  end

  assign ack_o = (op_o != OP_NONE);
endmodule

// File: rtl/wpl_state.sv
module wpl_state
  import wpl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       commit_i,
  input  logic       cap_en_i,
  input  wpl_op_e    cap_op_i,
  input  logic [7:0] cap_data_i,
  input  logic       wp_i,
  output wpl_state_t st_o,
  output logic       vol_cycle_o,
  output logic       nv_cycle_o
);
  wpl_state_t st_q;
  wpl_op_e    pend_q;
  logic [7:0] pend_data_q;
  logic       hw_lock;
  logic       nv_apply;
  logic       do_commit;

  assign hw_lock   = wp_i & st_q.lock_en;
  assign do_commit = commit_i && !pwr_up_i;
  assign nv_apply  = do_commit && (pend_q == OP_NV_REG) && !hw_lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= '0;
      pend_q      <= OP_NONE;
      pend_data_q <= '0;
    end else if (pwr_up_i) begin
      st_q.wen <= 1'b0;
      st_q.arm <= 1'b0;
      pend_q   <= OP_NONE;
    end else if (commit_i) begin
      unique case (pend_q)
        OP_SET_WEN: st_q.wen <= 1'b1;
        OP_CLR_WEN: begin
          st_q.wen <= 1'b0;
          st_q.arm <= 1'b0;
        end
        OP_SET_ARM: st_q.arm <= 1'b1;
        OP_NV_REG: if (!hw_lock) begin
          st_q.lock_en <= pend_data_q[BIT_LOCK];
          st_q.bp      <= {pend_data_q[BIT_BP1], pend_data_q[BIT_BP0]};
          st_q.arm     <= 1'b0;
        end
        default: ;
      endcase
      pend_q <= OP_NONE;
    end else if (cap_en_i) begin
      pend_q      <= cap_op_i;
      pend_data_q <= cap_data_i;
    end
  end

  assign st_o = st_q;

  always_comb begin
    vol_cycle_o = 1'b0;
    if (do_commit) begin
      unique case (pend_q)
        OP_SET_WEN, OP_CLR_WEN, OP_SET_ARM: vol_cycle_o = 1'b1;
        default: vol_cycle_o = 1'b0;
      endcase
    end
  end

  assign nv_cycle_o = nv_apply || (do_commit && (pend_q == OP_ARRAY));
endmodule

// File: rtl/wpl_timer.sv
module wpl_timer #(
  parameter int unsigned BUSY_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
  import wpl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BUSY_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_up_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic              req_single_i,
  input  logic              wp_i,
  input  logic              commit_i,
  output logic              ack_o,
  output logic              vol_cycle_o,
  output logic              nv_cycle_o,
  output logic              busy_o,
  output logic [7:0]        reg_rdata_o
);
  wpl_state_t st;
  wpl_op_e    op;
  logic       ack;
  logic       busy;
  logic       nv_start;

  wpl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_data_i   (req_data_i),
    .req_single_i (req_single_i),
    .st_i         (st),
    .wp_i         (wp_i),
    .busy_i       (busy),
    .ack_o        (ack),
    .op_o         (op)
  );

  wpl_state i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_up_i    (pwr_up_i),
    .commit_i    (commit_i),
    .cap_en_i    (ack),
    .cap_op_i    (op),
    .cap_data_i  (req_data_i),
    .wp_i        (wp_i),
    .st_o        (st),
    .vol_cycle_o (vol_cycle_o),
    .nv_cycle_o  (nv_start)
  );

  wpl_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (nv_start),
    .busy_o  (busy)
  );

  assign ack_o      = ack;
  assign busy_o     = busy;
  assign nv_cycle_o = nv_start;

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[BIT_WEN]  = st.wen;
    reg_rdata_o[BIT_ARM]  = st.arm;
    reg_rdata_o[BIT_BP0]  = st.bp[0];
    reg_rdata_o[BIT_BP1]  = st.bp[1];
    reg_rdata_o[BIT_LOCK] = st.lock_en;
  end
endmodule

// File: rtl/wpl_chk.sv
module wpl_chk #(
  parameter int unsigned BUSY_CYCLES = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_up_i,
  input logic       req_valid_i,
  input logic       wp_i,
  input logic       commit_i,
  input logic       ack_o,
  input logic       vol_cycle_o,
  input logic       nv_cycle_o,
  input logic       busy_o,
  input logic [7:0] reg_rdata_o
);
  int unsigned busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  // R1
  arm_needs_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[2] |-> reg_rdata_o[1]);

  // R2
  pwr_clears_latches_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_up_i |=> (reg_rdata_o[2:1] == 2'b00));

  // R2
  pwr_keeps_nv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_up_i |=> ({reg_rdata_o[7], reg_rdata_o[4:3]} == $past({reg_rdata_o[7], reg_rdata_o[4:3]})));

  // R8
  hw_lock_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && reg_rdata_o[7]) |=> (reg_rdata_o[7] && $stable(reg_rdata_o[4:3])));

  // R9
  no_change_without_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !pwr_up_i) |=> $stable(reg_rdata_o));

  // R9
  busy_follows_nv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_cycle_o |=> busy_o);

  // R9
  busy_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= BUSY_CYCLES);

  // R10
  cycle_kinds_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vol_cycle_o && nv_cycle_o));

  // R11
  no_ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_o);

  // R3
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> req_valid_i);
endmodule

bind wp_lock_ctrl wpl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_wpl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_up_i    (pwr_up_i),
  .req_valid_i (req_valid_i),
  .wp_i        (wp_i),
  .commit_i    (commit_i),
  .ack_o       (ack_o),
  .vol_cycle_o (vol_cycle_o),
  .nv_cycle_o  (nv_cycle_o),
  .busy_o      (busy_o),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/test_wp_lock_ctrl.sv
module test_wp_lock_ctrl;
  localparam int BUSY = 12;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        pwr = 0, valid = 0, single = 0, wp = 0, commit = 0;
  logic [10:0] addr = '0;
  logic [7:0]  data = '0;
  logic        ack, vol, nv, busy;
  logic [7:0]  rd;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_wen = 0, m_arm = 0, m_bp = 0, m_lock = 0, m_busy = 0, m_pop = 0;
  int m_pd = 0;

  always #4 clk = ~clk;

  wp_lock_ctrl #(.ADDR_W(11), .BUSY_CYCLES(BUSY)) i_wp_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(pwr), .req_valid_i(valid),
    .req_addr_i(addr), .req_data_i(data), .req_single_i(single), .wp_i(wp),
    .commit_i(commit), .ack_o(ack), .vol_cycle_o(vol), .nv_cycle_o(nv),
    .busy_o(busy), .reg_rdata_o(rd)
  );

  // 0 none, 1 set wen, 2 clear, 3 arm, 4 nv reg, 5 array
  function automatic int f_op();
    int hw;
    hw = (wp && m_lock != 0) ? 1 : 0;
    if (!valid || m_busy > 0) return 0;
    if (addr == 11'h7FF && single) begin
      if (data == 8'h00) return 2;
      if (data[6:5] == 2'b00 && data[2:1] == 2'b11) return (m_wen != 0) ? 3 : 0;
      if (m_arm != 0 && data[6:5] == 2'b00 && data[2:0] == 3'b010) return hw ? 0 : 4;
      if (data[7:1] == 7'd1) return 1;
      return 0;
    end
    if (m_wen == 0) return 0;
    if (m_bp == 3) return 0;
    if (m_bp == 2 && addr >= 11'h400) return 0;
    if (m_bp == 1 && addr >= 11'h600) return 0;
    return 5;
  endfunction

  function automatic logic [7:0] f_rd();
    return {m_lock[0], 2'b00, m_bp[1], m_bp[0], m_arm[0], m_wen[0], 1'b0};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wen = 0; m_arm = 0; m_bp = 0; m_lock = 0; m_busy = 0; m_pop = 0; m_pd = 0;
    end else begin
      int op;
      op = f_op();
      if (m_busy > 0) m_busy--;
      if (pwr) begin
        m_wen = 0; m_arm = 0; m_pop = 0;
      end else if (commit) begin
        case (m_pop)
          1: m_wen = 1;
          2: begin m_wen = 0; m_arm = 0; end
          3: m_arm = 1;
          4: if (!(wp && m_lock != 0)) begin
               m_lock = (m_pd >> 7) & 1; m_bp = (m_pd >> 3) & 3; m_arm = 0; m_busy = BUSY;
             end
          5: m_busy = BUSY;
          default: ;
        endcase
        m_pop = 0;
      end else if (op != 0) begin
        m_pop = op; m_pd = data;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_vol, e_nv;
      e_vol = (commit && !pwr && (m_pop >= 1 && m_pop <= 3)) ? 1 : 0;
      e_nv  = (commit && !pwr && (m_pop == 5 || (m_pop == 4 && !(wp && m_lock != 0)))) ? 1 : 0;
      chk("R3", "ack_o", ack, (f_op() != 0) ? 1 : 0);
      chk("R1", "reg_rdata_o", rd, f_rd());
      chk("R9", "busy_o", busy, (m_busy > 0) ? 1 : 0);
      chk("R10", "vol_cycle_o", vol, e_vol);
      chk("R9", "nv_cycle_o", nv, e_nv);
    end
  end

  task automatic req(input logic [10:0] a, input logic [7:0] d, input logic s,
                     input int exp_ack, input string tag);
    @(posedge clk); #1;
    valid = 1; addr = a; data = d; single = s;
    @(negedge clk);
    chk(tag, "ack_o", ack, exp_ack);
    @(posedge clk); #1;
    valid = 0;
  endtask

  task automatic do_commit(input int exp_vol, input int exp_nv, input string tag);
    @(posedge clk); #1;
    commit = 1;
    @(negedge clk);
    chk(tag, "vol_cycle_o", vol, exp_vol);
    chk(tag, "nv_cycle_o", nv, exp_nv);
    @(posedge clk); #1;
    commit = 0;
  endtask

  task automatic rd_is(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(tag, "reg_rdata_o", rd, exp);
  endtask

  task automatic wait_busy();
    repeat (BUSY + 2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_is(8'h00, "R1");
    // R3: array write refused while the enable latch is clear
    req(11'h100, 8'h55, 1'b0, 0, "R3");
    // R5/R10: enable latch
    req(11'h7FF, 8'h02, 1'b1, 1, "R5");
    do_commit(1, 0, "R10");
    rd_is(8'h02, "R5");
    // R9/R11: array write starts a nonvolatile cycle; requests refused while busy
    req(11'h100, 8'h55, 1'b0, 1, "R3");
    do_commit(0, 1, "R9");
    req(11'h7FF, 8'h00, 1'b1, 0, "R11");
    wait_busy();
    // R9: clear stays pending until commit
    req(11'h7FF, 8'h00, 1'b1, 1, "R5");
    rd_is(8'h02, "R9");
    do_commit(1, 0, "R5");
    rd_is(8'h00, "R5");
    // R6/R7: unlock sequence, block protect quarter
    req(11'h7FF, 8'h02, 1'b1, 1, "R5");
    do_commit(1, 0, "R10");
    req(11'h7FF, 8'h0A, 1'b1, 0, "R7");
    req(11'h7FF, 8'h06, 1'b1, 1, "R6");
    do_commit(1, 0, "R6");
    rd_is(8'h06, "R6");
    req(11'h7FF, 8'h0A, 1'b1, 1, "R7");
    do_commit(0, 1, "R7");
    rd_is(8'h0A, "R7");
    wait_busy();
    // R4: upper quarter protected
    req(11'h600, 8'h11, 1'b0, 0, "R4");
    req(11'h5FF, 8'h11, 1'b0, 1, "R4");
    req(11'h7FF, 8'h11, 1'b0, 0, "R4");
    // R6: arm pattern carrying protect bits leaves them unchanged
    req(11'h7FF, 8'h16, 1'b1, 1, "R6");
    do_commit(1, 0, "R6");
    rd_is(8'h0E, "R6");
    // R7: lock enable and half protection
    req(11'h7FF, 8'h92, 1'b1, 1, "R7");
    do_commit(0, 1, "R7");
    rd_is(8'h92, "R7");
    wait_busy();
    // R8: pin high locks the nonvolatile bits
    wp = 1;
    req(11'h7FF, 8'h06, 1'b1, 1, "R6");
    do_commit(1, 0, "R6");
    rd_is(8'h96, "R6");
    req(11'h7FF, 8'h02, 1'b1, 0, "R8");
    req(11'h100, 8'h33, 1'b0, 1, "R8");
    req(11'h400, 8'h33, 1'b0, 0, "R4");
    // R8: pending nv write dropped when lock active at commit
    wp = 0;
    req(11'h7FF, 8'h02, 1'b1, 1, "R7");
    wp = 1;
    do_commit(0, 0, "R8");
    rd_is(8'h96, "R8");
    // R2: power-up clears latches only
    @(posedge clk); #1; pwr = 1;
    @(posedge clk); #1; pwr = 0;
    rd_is(8'h90, "R2");
    // R4: full protection after unlock with pin low
    wp = 0;
    req(11'h7FF, 8'h02, 1'b1, 1, "R5");
    do_commit(1, 0, "R5");
    req(11'h7FF, 8'h06, 1'b1, 1, "R6");
    do_commit(1, 0, "R6");
    req(11'h7FF, 8'h1A, 1'b1, 1, "R7");
    do_commit(0, 1, "R7");
    rd_is(8'h1A, "R7");
    wait_busy();
    req(11'h000, 8'h44, 1'b0, 0, "R4");
    req(11'h7FF, 8'h44, 1'b0, 0, "R4");
    repeat (4) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule